// File: doc/BRIEF.md
# Parallel port interrupt controller

This block is the port-register and interrupt section of a general-purpose interface adapter. It holds two 8-bit port output registers with their direction registers, a peripheral control register that configures four external control lines (two belonging to port A, two to port B), an interrupt flag register and an interrupt enable register. A processor reaches these through a 4-bit register address with separate read and write strobes.

Each control line passes through a synchronizer and an edge detector. The edge that the control register selects for a line latches that line's flag. Three on-chip request inputs, one from a shift-register engine and one from each of two timers, set their flags directly. The enabled flags are ORed onto one active-low interrupt output. Software clears flags by writing ones to the flag register. Any access to a port clears that port's control-line flags, except that a secondary control line in independent mode keeps its flag.

Each control line's edge detector is a two-state machine. `LINE_LOW` moves to `LINE_HIGH` on a synchronized high level and reports a rising edge. `LINE_HIGH` moves to `LINE_LOW` on a synchronized low level and reports a falling edge. In every other case the state holds and nothing is reported.

Top module: `pport_irq_ctrl`

## Requirements
- R1: Reset clears both port registers, both direction registers, the control register, all flags and all enables. After reset `irq_n` is 1, the flag register reads 0x00 and the enable register reads 0x80.
- R2: Register addresses: 0 port B, 1 port A, 2 port B direction, 3 port A direction, 12 control, 13 flags, 14 enables, 15 port A without handshake. Addresses 1 and 15 reach the same port A register. All other addresses read 0x00 and ignore writes.
- R3: A port write changes only the bits whose direction bit is 1. A port read returns the port register.
- R4: Control-line flags are flag bit 1 for the first port A line, bit 0 for the second port A line, bit 4 for the first port B line and bit 3 for the second port B line. Each flag is set by one edge of its line, chosen by a polarity bit in the control register: bit 0, bit 2, bit 4 and bit 6 respectively, where 1 selects the rising edge and 0 the falling edge. The opposite edge sets nothing. The flag becomes visible SYNC_STAGES+1 clock edges after the input changes.
- R5: When control bit 3 is 1, the second port A line sets no flag. When control bit 7 is 1, the second port B line sets no flag.
- R6: Each clock edge at which `shift_req` is 1 sets flag bit 2, including again directly after a clear.
- R7: Each clock edge at which `tmr1_req` is 1 sets flag bit 6. Each clock edge at which `tmr2_req` is 1 sets flag bit 5.
- R8: A read or write of port B clears flag bit 4. It also clears flag bit 3, unless control bits [7:5] are 0,x,1, which is independent mode.
- R9: A read or write of port A at address 1 or address 15 clears flag bit 1. It also clears flag bit 0, unless control bits [3:1] are 0,x,1, which is independent mode.
- R10: A write to the flag register clears every flag at whose position wdata[6:0] holds a 1. Flag register bit 7 reads 1 exactly when some enabled flag is set.
- R11: A write to the enable register sets the enables marked by wdata[6:0] when wdata[7] is 1, and clears them when wdata[7] is 0. Enable register bit 7 reads 1.
- R12: `irq_n` is 0 exactly when flags[6:0] AND enables[6:0] is nonzero. It follows the flag and enable registers without added delay.
- R13: When a flag is set and cleared at the same clock edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe; triggers the flag clears of a port read |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pa_out | output | 8 | Port A output register |
| pa_dir | output | 8 | Port A direction (1 = output) |
| pb_out | output | 8 | Port B output register |
| pb_dir | output | 8 | Port B direction (1 = output) |
| ctl_a1 | input | 1 | Port A first control line |
| ctl_a2 | input | 1 | Port A second control line |
| ctl_b1 | input | 1 | Port B first control line |
| ctl_b2 | input | 1 | Port B second control line |
| shift_req | input | 1 | Shift-register interrupt request |
| tmr1_req | input | 1 | Timer 1 interrupt request |
| tmr2_req | input | 1 | Timer 2 interrupt request |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. It derives its wait after each control-line change from that parameter, so every edge is sampled only after it has had time to reach the flag register. With this setting, each control-line polarity and mode combination can be tested in a few cycles. The short latency also lets the bench hold a request active during a flag-register write, which exercises the same-edge set and clear case.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_FLAGS = 7;
    localparam int NUM_LINES = 4;

    localparam logic [3:0] ADDR_PORTB    = 4'd0;
    localparam logic [3:0] ADDR_PORTA    = 4'd1;
    localparam logic [3:0] ADDR_DIRB     = 4'd2;
    localparam logic [3:0] ADDR_DIRA     = 4'd3;
    localparam logic [3:0] ADDR_CTRL     = 4'd12;
    localparam logic [3:0] ADDR_FLAGS    = 4'd13;
    localparam logic [3:0] ADDR_ENABLE   = 4'd14;
    localparam logic [3:0] ADDR_PORTA_NH = 4'd15;

    // flag bit positions
    localparam int FL_A2  = 0;
    localparam int FL_A1  = 1;
    localparam int FL_SHF = 2;
    localparam int FL_B2  = 3;
    localparam int FL_B1  = 4;
    localparam int FL_T2  = 5;
    localparam int FL_T1  = 6;

    // control line index into synchronizer / edge detector arrays
    localparam int LN_A1 = 0;
    localparam int LN_A2 = 1;
    localparam int LN_B1 = 2;
    localparam int LN_B2 = 3;

    typedef enum logic {LINE_LOW = 1'b0, LINE_HIGH = 1'b1} line_state_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0] chain_q [WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[i] <= '0;
            end else begin
                chain_q[i] <= {chain_q[i][STAGES-2:0], d[i]};
            end
        end
        assign q[i] = chain_q[i][STAGES-1];
    end
endmodule

// File: rtl/pic_edge_det.sv
module pic_edge_det
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW:  if (lvl)  state_d = LINE_HIGH;
            LINE_HIGH: if (!lvl) state_d = LINE_LOW;
            default:   state_d = LINE_LOW;
        endcase
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            LINE_LOW:  rise = lvl;
            LINE_HIGH: fall = !lvl;
            default:   begin rise = 1'b0; fall = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pic_flags.sv
module pic_flags #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_mask,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            // a new event outranks a clear in the same cycle
            flags <= (flags & ~clr_mask) | set_mask;
        end
    end
endmodule

// File: rtl/pport_irq_ctrl.sv
module pport_irq_ctrl
    import pic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_dir,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_dir,
    input  logic              ctl_a1,
    input  logic              ctl_a2,
    input  logic              ctl_b1,
    input  logic              ctl_b2,
    input  logic              shift_req,
    input  logic              tmr1_req,
    input  logic              tmr2_req,
    output logic              irq_n
);
    logic [DATA_W-1:0]    pa_q, pb_q, da_q, db_q, ctrl_q;
    logic [NUM_FLAGS-1:0] ien_q;
    logic [NUM_FLAGS-1:0] flag_q, flag_set, flag_clr;
    logic [NUM_LINES-1:0] line_raw, line_sync, line_rise, line_fall;
    logic [NUM_LINES-1:0] line_pol, line_in_mode, line_ev;
    logic                 a2_indep, b2_indep, pa_access, pb_access, any_access;

    assign line_raw = {ctl_b2, ctl_b1, ctl_a2, ctl_a1};

    pic_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_LINES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (line_raw),
        .q    (line_sync)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        pic_edge_det edge_i (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (line_sync[i]),
            .rise (line_rise[i]),
            .fall (line_fall[i])
        );
        assign line_ev[i] = line_in_mode[i] & (line_pol[i] ? line_rise[i] : line_fall[i]);
    end

    // control register decode
    assign line_pol[LN_A1]     = ctrl_q[0];
    assign line_pol[LN_A2]     = ctrl_q[2];
    assign line_pol[LN_B1]     = ctrl_q[4];
    assign line_pol[LN_B2]     = ctrl_q[6];
    assign line_in_mode[LN_A1] = 1'b1;
    assign line_in_mode[LN_A2] = !ctrl_q[3];
    assign line_in_mode[LN_B1] = 1'b1;
    assign line_in_mode[LN_B2] = !ctrl_q[7];
    assign a2_indep = !ctrl_q[3] && ctrl_q[1];
    assign b2_indep = !ctrl_q[7] && ctrl_q[5];

    assign any_access = rd_en || wr_en;
    assign pa_access  = any_access && (addr == ADDR_PORTA || addr == ADDR_PORTA_NH);
    assign pb_access  = any_access && (addr == ADDR_PORTB);

    always_comb begin
        flag_set         = '0;
        flag_set[FL_A1]  = line_ev[LN_A1];
        flag_set[FL_A2]  = line_ev[LN_A2];
        flag_set[FL_B1]  = line_ev[LN_B1];
        flag_set[FL_B2]  = line_ev[LN_B2];
        flag_set[FL_SHF] = shift_req;
        flag_set[FL_T1]  = tmr1_req;
        flag_set[FL_T2]  = tmr2_req;

        flag_clr = '0;
        if (wr_en && addr == ADDR_FLAGS) begin
            flag_clr = wdata[NUM_FLAGS-1:0];
        end
        if (pa_access) begin
            flag_clr[FL_A1] = 1'b1;
            if (!a2_indep) flag_clr[FL_A2] = 1'b1;
        end
        if (pb_access) begin
            flag_clr[FL_B1] = 1'b1;
            if (!b2_indep) flag_clr[FL_B2] = 1'b1;
        end
    end

    pic_flags #(.WIDTH(NUM_FLAGS)) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mask(flag_set),
        .clr_mask(flag_clr),
        .flags   (flag_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa_q   <= '0;
            pb_q   <= '0;
            da_q   <= '0;
            db_q   <= '0;
            ctrl_q <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_PORTB:                 pb_q   <= (pb_q & ~db_q) | (wdata & db_q);
                ADDR_PORTA, ADDR_PORTA_NH:  pa_q   <= (pa_q & ~da_q) | (wdata & da_q);
                ADDR_DIRB:                  db_q   <= wdata;
                ADDR_DIRA:                  da_q   <= wdata;
                ADDR_CTRL:                  ctrl_q <= wdata;
                ADDR_ENABLE: begin
                    if (wdata[DATA_W-1]) ien_q <= ien_q | wdata[NUM_FLAGS-1:0];
                    else                 ien_q <= ien_q & ~wdata[NUM_FLAGS-1:0];
                end
                default: ;
            endcase
        end
    end

    logic irq_any;
    assign irq_any = |(flag_q & ien_q);
    assign irq_n   = !irq_any;

    always_comb begin
        unique case (addr)
            ADDR_PORTB:                rdata = pb_q;
            ADDR_PORTA, ADDR_PORTA_NH: rdata = pa_q;
            ADDR_DIRB:                 rdata = db_q;
            ADDR_DIRA:                 rdata = da_q;
            ADDR_CTRL:                 rdata = ctrl_q;
            ADDR_FLAGS:                rdata = {irq_any, flag_q};
            ADDR_ENABLE:               rdata = {1'b1, ien_q};
            default:                   rdata = '0;
        endcase
    end

    assign pa_out = pa_q;
    assign pa_dir = da_q;
    assign pb_out = pb_q;
    assign pb_dir = db_q;
endmodule

// File: rtl/pport_irq_chk.sv
module pport_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] addr,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] pb_out,
    input logic [7:0] pb_dir,
    input logic       shift_req,
    input logic       tmr1_req,
    input logic [6:0] flags,
    input logic [6:0] ien,
    input logic       b1_event
);
    // R3: input-direction bits of port B keep their value across a write
    p_dir_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd0) |=> (((pb_out ^ $past(pb_out)) & ~$past(pb_dir)) == 8'h00));

    // R6: shift request always lands in its flag
    p_shift_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_req |=> flags[2]);

    // R7: timer 1 request always lands in its flag
    p_tmr1_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr1_req |=> flags[6]);

    // R11: set-type enable write turns on every marked enable
    p_enable_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd14 && wdata[7]) |=> ((ien & $past(wdata[6:0])) == $past(wdata[6:0])));

    // R8: port B access without a new line event leaves its first flag clear
    p_portb_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && addr == 4'd0 && !b1_event) |=> !flags[4]);
endmodule

bind pport_irq_ctrl pport_irq_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .pb_out   (pb_out),
    .pb_dir   (pb_dir),
    .shift_req(shift_req),
    .tmr1_req (tmr1_req),
    .flags    (flag_q),
    .ien      (ien_q),
    .b1_event (line_ev[2])
);

// File: tb/pport_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pport_irq_ctrl_tb_top;
    localparam int SYNC_STAGES = 2;
    localparam int LAT = SYNC_STAGES + 2;
    localparam int NVEC = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, pa_out, pa_dir, pb_out, pb_dir;
    logic       ctl_a1 = 0, ctl_a2 = 0, ctl_b1 = 0, ctl_b2 = 0;
    logic       shift_req = 0, tmr1_req = 0, tmr2_req = 0;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pport_irq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .pa_out(pa_out), .pa_dir(pa_dir),
        .pb_out(pb_out), .pb_dir(pb_dir), .ctl_a1(ctl_a1), .ctl_a2(ctl_a2),
        .ctl_b1(ctl_b1), .ctl_b2(ctl_b2), .shift_req(shift_req),
        .tmr1_req(tmr1_req), .tmr2_req(tmr2_req), .irq_n(irq_n)
    );

    // {is_read, addr, data, expected}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 4'd2,  8'h0F, 8'h00},
        {1'b0, 4'd0,  8'hFF, 8'h00},
        {1'b1, 4'd0,  8'h00, 8'h0F},
        {1'b0, 4'd2,  8'hF0, 8'h00},
        {1'b0, 4'd0,  8'h00, 8'h00},
        {1'b1, 4'd0,  8'h00, 8'h0F},
        {1'b0, 4'd3,  8'hFF, 8'h00},
        {1'b0, 4'd1,  8'hA5, 8'h00},
        {1'b1, 4'd15, 8'h00, 8'hA5},
        {1'b1, 4'd1,  8'h00, 8'hA5},
        {1'b0, 4'd12, 8'h5A, 8'h00},
        {1'b1, 4'd12, 8'h00, 8'h5A},
        {1'b0, 4'd4,  8'h33, 8'h00},
        {1'b1, 4'd4,  8'h00, 8'h00},
        {1'b0, 4'd14, 8'h83, 8'h00},
        {1'b1, 4'd14, 8'h00, 8'h83},
        {1'b0, 4'd14, 8'h01, 8'h00},
        {1'b1, 4'd14, 8'h00, 8'h82},
        {1'b0, 4'd14, 8'h02, 8'h00},
        {1'b1, 4'd14, 8'h00, 8'h80},
        {1'b1, 4'd13, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 chk(tag, rdata, exp);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (LAT) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
        chk("R1 pb_out", pb_out, 8'h00);
        rd(4'd13, 8'h00, "R1 flags");
        rd(4'd14, 8'h80, "R1 enables");

        // register vectors: R2/R3/R11
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][20]) rd(VEC[i][19:16], VEC[i][7:0], $sformatf("R2/R3/R11 vector %0d", i));
            else            wr(VEC[i][19:16], VEC[i][15:8]);
        end
        @(negedge clk);
        chk("R3 pb_out port", pb_out, 8'h0F);
        chk("R3 pa_out port", pa_out, 8'hA5);

        // R4 rising polarity on first port A line
        wr(4'd12, 8'h11);
        @(negedge clk); ctl_a1 = 1; settle();
        rd(4'd13, 8'h02, "R4 a1 rising");
        wr(4'd13, 8'h7F);
        @(negedge clk); ctl_a1 = 0; settle();
        rd(4'd13, 8'h00, "R4 a1 wrong edge");
        // R4 falling polarity
        wr(4'd12, 8'h00);
        @(negedge clk); ctl_a1 = 1; settle();
        rd(4'd13, 8'h00, "R4 a1 rise ignored");
        @(negedge clk); ctl_a1 = 0; settle();
        // R12 irq follows enables, R10 bit 7
        @(negedge clk);
        chk("R12 irq masked", {7'b0, irq_n}, 8'h01);
        wr(4'd14, 8'h82);
        @(negedge clk);
        chk("R12 irq asserted", {7'b0, irq_n}, 8'h00);
        rd(4'd13, 8'h82, "R10 summary bit");
        // R9 port A read clears
        rd(4'd1, 8'hA5, "R9 port A read");
        rd(4'd13, 8'h00, "R9 a1 cleared");
        @(negedge clk);
        chk("R12 irq released", {7'b0, irq_n}, 8'h01);

        // R9 independent mode keeps second A flag
        wr(4'd12, 8'h02);
        @(negedge clk); ctl_a2 = 1; settle();
        @(negedge clk); ctl_a2 = 0; settle();
        rd(4'd13, 8'h01, "R4 a2 falling");
        wr(4'd1, 8'h5A);
        rd(4'd13, 8'h01, "R9 a2 independent kept");
        wr(4'd13, 8'h01);
        rd(4'd13, 8'h00, "R10 write-one clear");
        // R9 handshake-free address clears non-independent flag
        wr(4'd12, 8'h04);
        @(negedge clk); ctl_a2 = 1; settle();
        rd(4'd13, 8'h01, "R4 a2 rising");
        rd(4'd15, 8'h5A, "R9 port A alt read");
        rd(4'd13, 8'h00, "R9 a2 cleared via 15");

        // R8 port B lines
        wr(4'd12, 8'h50);
        @(negedge clk); ctl_b1 = 1; ctl_b2 = 1; settle();
        rd(4'd13, 8'h18, "R4 b1/b2 rising");
        wr(4'd0, 8'h00);
        rd(4'd13, 8'h00, "R8 port B write clears");
        wr(4'd12, 8'h70);
        @(negedge clk); ctl_b2 = 0; settle();
        @(negedge clk); ctl_b2 = 1; ctl_b1 = 0; settle();
        rd(4'd13, 8'h08, "R4 b2 independent set");
        rd(4'd0, 8'h0F, "R8 port B read");
        rd(4'd13, 8'h08, "R8 b2 independent kept");
        wr(4'd13, 8'h08);

        // R5 output mode sets nothing
        wr(4'd12, 8'hC0);
        @(negedge clk); ctl_b2 = 0; settle();
        @(negedge clk); ctl_b2 = 1; settle();
        rd(4'd13, 8'h00, "R5 b2 output mode");

        // R6 shift request
        @(negedge clk); shift_req = 1;
        @(negedge clk); shift_req = 0;
        rd(4'd13, 8'h04, "R6 shift flag");
        // R13 set wins over clear
        @(negedge clk); shift_req = 1;
        wr(4'd13, 8'h04);
        @(negedge clk); shift_req = 0;
        rd(4'd13, 8'h04, "R13 set beats clear");
        wr(4'd13, 8'h04);
        rd(4'd13, 8'h00, "R6 shift cleared");

        // R7 timers
        @(negedge clk); tmr1_req = 1;
        @(negedge clk); tmr1_req = 0; tmr2_req = 1;
        @(negedge clk); tmr2_req = 0;
        rd(4'd13, 8'h60, "R7 timer flags");
        chk("R12 timers masked", {7'b0, irq_n}, 8'h01);
        wr(4'd14, 8'hC0);
        @(negedge clk);
        chk("R12 timers enabled", {7'b0, irq_n}, 8'h00);
        rd(4'd13, 8'hE0, "R10 summary with timers");
        wr(4'd14, 8'h7F);
        rd(4'd14, 8'h80, "R11 clear all enables");
        @(negedge clk);
        chk("R12 irq after disable", {7'b0, irq_n}, 8'h01);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule